// File: doc/BRIEF.md
# Sprite XOR Drawing Engine

This block draws byte-wide monochrome sprites into a 64x32 pixel framebuffer that sits in a shared byte-wide RAM. A host raises a one-cycle start request together with the sprite's RAM address, its row count and a pixel position. The engine then works through the sprite one row at a time. It reads the sprite byte and shifts it by the pixel offset inside a screen byte, so one sprite row covers at most two neighbouring screen bytes. It reads both screen bytes, XORs the sprite into them and writes them back.

While it works, the engine drives its own RAM address lines and holds a busy flag. It also records whether any pixel that was already lit got drawn over. The host waits for busy to fall and then reads the collision flag. The RAM it drives must return read data two clock cycles after the engine sets up a read address. Writes take effect one clock edge after the engine registers them.

Top module: `sprite_blit`

## Requirements
- R1: While rst is high, and on the first cycle after it falls, busy, collision and ram_we are all 0.
- R2: A start request (draw high while busy is low) with a row count N from 1 to 15 raises busy on the next cycle. Busy then stays high for exactly 5*N+1 cycles, and the last of these cycles is the one in which the final screen write reaches the RAM.
- R3: Sprite row k (k = 0..N-1) is read from RAM address (A + k) mod 4096, where A is the 12-bit start address.
- R4: For row k, the engine writes the left screen byte first and the right screen byte second. The left byte is at 0x100 + ((Y+k) mod 32)*8 + X/8. The right byte is at 0x100 + ((Y+k) mod 32)*8 + ((X/8 + 1) mod 8). Drawing therefore wraps horizontally and vertically.
- R5: Bit 7 of a sprite byte, and of a screen byte, is the leftmost pixel. The sprite byte is placed in the upper half of a 16-bit word, and the word is shifted right by X mod 8. The left byte is written as old XOR word[15:8], and the right byte as old XOR word[7:0].
- R6: Collision is cleared when a start request is taken. It is set if any old screen bit ANDed with the matching sprite bit is 1, in either byte of any row. It then holds its value until the next start request.
- R7: A draw request that arrives while busy is high has no effect. The screen result and the busy length are those of the running draw alone, and collision is not cleared.
- R8: A start request with N = 0 leaves busy low, clears collision and makes no RAM write.
- R9: The engine sets up each read address and consumes the returned data exactly two cycles later. Sprite, left and right reads are issued on three consecutive cycles.
- R10: ram_we is high only while busy is high, and every write address falls in 0x100..0x1FF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| draw | input | 1 | Start request, taken only while idle |
| spr_addr | input | 12 | RAM address of the first sprite row |
| spr_rows | input | 4 | Number of sprite rows N |
| pos_x | input | 6 | Horizontal pixel position |
| pos_y | input | 5 | Vertical pixel position |
| busy | output | 1 | High while a draw is running |
| collision | output | 1 | Pixel overlap flag of the most recent draw |
| ram_rd_addr | output | 12 | Registered RAM read address |
| ram_rd_data | input | 8 | RAM read data, two cycles after the address |
| ram_wr_addr | output | 12 | Registered RAM write address |
| ram_wr_data | output | 8 | Registered RAM write data |
| ram_we | output | 1 | Registered RAM write enable |

## Verification
The bench builds the engine with its default widths: a 12-bit address, 8-bit data, 6-bit X, 5-bit Y and 4-bit row count. With these widths the full 64x32 wrap, sprite addresses that wrap past 0xFFF and the largest sprite of 15 rows can all be driven. Positions at X = 61 and Y = 30 make a sprite cross both the right and the bottom screen edges. Sub-byte offsets exercise both halves of the shifted word. The RAM model in the bench has the required two-cycle read latency, so any mistake in the read-to-use alignment shows up as wrong pixels.

// File: rtl/sprite_blit_pkg.sv
package sprite_blit_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GET_SPR,
        ST_GET_L,
        ST_GET_R,
        ST_PUT_L,
        ST_PUT_R,
        ST_DRAIN
    } blit_state_e;

endpackage

// File: rtl/blit_addr_gen.sv
// Maps a sprite row onto the two framebuffer bytes it touches, with wrap.
module blit_addr_gen #(
    parameter int AW      = 12,
    parameter int COLW    = 3,
    parameter int YW      = 5,
    parameter int NW      = 4,
    parameter logic [AW-1:0] FB_BASE = 12'h100
) (
    input  logic [COLW-1:0] x_col,
    input  logic [YW-1:0]   y_pos,
    input  logic [NW-1:0]   row,
    output logic [AW-1:0]   left_addr,
    output logic [AW-1:0]   right_addr
);
    localparam int OFFW = YW + COLW;

    logic [YW-1:0]   y_wrap;
    logic [COLW-1:0] x_next;

    always_comb begin
        y_wrap     = y_pos + YW'(row);
        x_next     = x_col + COLW'(1);
        left_addr  = FB_BASE + AW'({y_wrap, x_col});
        right_addr = FB_BASE + AW'({y_wrap, x_next});
    end

    if (OFFW > AW) begin : g_bad_width
        initial $error("framebuffer offset wider than address");
    end
endmodule

// File: rtl/blit_row_shift.sv
// Places a sprite byte at the top of a double-width word and shifts it by the sub-byte offset.
module blit_row_shift #(
    parameter int DW  = 8,
    parameter int SHW = 3
) (
    input  logic [DW-1:0]   row_in,
    input  logic [SHW-1:0]  offset,
    output logic [2*DW-1:0] row_out
);
    always_comb begin
        row_out = {row_in, {DW{1'b0}}} >> offset;
    end
endmodule

// File: rtl/sprite_blit.sv
module sprite_blit
    import sprite_blit_pkg::*;
#(
    parameter int AW = 12,
    parameter int DW = 8,
    parameter int XW = 6,
    parameter int YW = 5,
    parameter int NW = 4,
    parameter logic [AW-1:0] FB_BASE = 12'h100
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          draw,
    input  logic [AW-1:0] spr_addr,
    input  logic [NW-1:0] spr_rows,
    input  logic [XW-1:0] pos_x,
    input  logic [YW-1:0] pos_y,
    output logic          busy,
    output logic          collision,
    output logic [AW-1:0] ram_rd_addr,
    input  logic [DW-1:0] ram_rd_data,
    output logic [AW-1:0] ram_wr_addr,
    output logic [DW-1:0] ram_wr_data,
    output logic          ram_we
);
    localparam int SHW      = $clog2(DW);
    localparam int COLW     = XW - SHW;
    localparam int FB_BYTES = (1 << COLW) * (1 << YW);

    typedef struct packed {
        blit_state_e     st;
        logic [NW-1:0]   row;
        logic [NW-1:0]   rows;
        logic [AW-1:0]   base;
        logic [XW-1:0]   x;
        logic [YW-1:0]   y;
        logic [2*DW-1:0] word;
        logic            coll;
        logic [AW-1:0]   ra;
        logic [AW-1:0]   wa;
        logic [DW-1:0]   wd;
        logic            we;
    } regs_t;

    regs_t r_q, r_d;

    logic [AW-1:0]   left_addr, right_addr;
    logic [2*DW-1:0] shifted;
    logic [DW-1:0]   hi_half, lo_half;

    blit_addr_gen #(
        .AW(AW), .COLW(COLW), .YW(YW), .NW(NW), .FB_BASE(FB_BASE)
    ) u_addr (
        .x_col     (r_q.x[XW-1:SHW]),
        .y_pos     (r_q.y),
        .row       (r_q.row),
        .left_addr (left_addr),
        .right_addr(right_addr)
    );

    blit_row_shift #(.DW(DW), .SHW(SHW)) u_shift (
        .row_in (ram_rd_data),
        .offset (r_q.x[SHW-1:0]),
        .row_out(shifted)
    );

    assign hi_half = r_q.word[2*DW-1:DW];
    assign lo_half = r_q.word[DW-1:0];

    always_comb begin
        r_d    = r_q;
        r_d.we = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (draw) begin
                    r_d.coll = 1'b0;
                    if (spr_rows != '0) begin
                        r_d.rows = spr_rows;
                        r_d.row  = '0;
                        r_d.base = spr_addr;
                        r_d.x    = pos_x;
                        r_d.y    = pos_y;
                        r_d.st   = ST_GET_SPR;
                    end
                end
            end
            ST_GET_SPR: begin
                r_d.ra = r_q.base + AW'(r_q.row);
                r_d.st = ST_GET_L;
            end
            ST_GET_L: begin
                r_d.ra = left_addr;
                r_d.st = ST_GET_R;
            end
            ST_GET_R: begin
                // sprite byte issued two cycles ago is on the read bus now
                r_d.ra   = right_addr;
                r_d.word = shifted;
                r_d.st   = ST_PUT_L;
            end
            ST_PUT_L: begin
                r_d.wa   = left_addr;
                r_d.wd   = ram_rd_data ^ hi_half;
                r_d.we   = 1'b1;
                r_d.coll = r_q.coll | (|(ram_rd_data & hi_half));
                r_d.st   = ST_PUT_R;
            end
            ST_PUT_R: begin
                r_d.wa   = right_addr;
                r_d.wd   = ram_rd_data ^ lo_half;
                r_d.we   = 1'b1;
                r_d.coll = r_q.coll | (|(ram_rd_data & lo_half));
                if (r_q.row == r_q.rows - NW'(1)) begin
                    r_d.st = ST_DRAIN;
                end else begin
                    r_d.row = r_q.row + NW'(1);
                    r_d.st  = ST_GET_SPR;
                end
            end
            ST_DRAIN: r_d.st = ST_IDLE;
            default:  r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy        = (r_q.st != ST_IDLE);
    assign collision   = r_q.coll;
    assign ram_rd_addr = r_q.ra;
    assign ram_wr_addr = r_q.wa;
    assign ram_wr_data = r_q.wd;
    assign ram_we      = r_q.we;

    // R10: writes stay inside the framebuffer and occur only during a draw
    assert_wr_in_fb_R10: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> (ram_wr_addr >= FB_BASE) &&
                   (ram_wr_addr < FB_BASE + AW'(FB_BYTES)));
    assert_we_busy_R10: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> busy);
    // R4: two writes in a row go to distinct bytes
    assert_we_pair_R4: assert property (@(posedge clk) disable iff (rst)
        (ram_we && $past(ram_we)) |-> (ram_wr_addr != $past(ram_wr_addr)));
    // R6: cleared on start, held otherwise
    assert_coll_clear_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !collision);
    assert_coll_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (collision && !(draw && !busy)) |=> collision);
    // R8: an empty sprite never starts a draw
    assert_zero_rows_R8: assert property (@(posedge clk) disable iff (rst)
        (!busy && draw && spr_rows == '0) |=> !busy);
    // R7: a running draw is not restarted by a new request
    assert_ignore_R7: assert property (@(posedge clk) disable iff (rst)
        (busy && r_q.st != ST_DRAIN) |=> busy);
    // R9: read addresses step sprite -> left -> right on consecutive cycles
    assert_read_order_R9: assert property (@(posedge clk) disable iff (rst)
        (r_q.st == ST_PUT_L) |-> (ram_rd_addr == right_addr) &&
                                 ($past(ram_rd_addr) == left_addr));
endmodule

// File: tb/sim_sprite_blit.sv
module sim_sprite_blit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        draw = 1'b0;
    logic [11:0] spr_addr = '0;
    logic [3:0]  spr_rows = '0;
    logic [5:0]  pos_x = '0;
    logic [4:0]  pos_y = '0;
    logic        busy, collision, ram_we;
    logic [11:0] ram_rd_addr, ram_wr_addr;
    logic [7:0]  ram_rd_data, ram_wr_data;

    logic        ld_en = 1'b0;
    logic [11:0] ld_a = '0;
    logic [7:0]  ld_d = '0;
    logic [7:0]  mem [0:4095];
    logic [7:0]  ref_fb [0:255];

    int checks = 0;
    int errors = 0;
    int we_seen = 0;

    always #10 clk = ~clk;   // 50 MHz

    sprite_blit u0 (
        .clk(clk), .rst(rst), .draw(draw), .spr_addr(spr_addr),
        .spr_rows(spr_rows), .pos_x(pos_x), .pos_y(pos_y),
        .busy(busy), .collision(collision),
        .ram_rd_addr(ram_rd_addr), .ram_rd_data(ram_rd_data),
        .ram_wr_addr(ram_wr_addr), .ram_wr_data(ram_wr_data), .ram_we(ram_we)
    );

    // RAM model: registered address from the engine plus one read register = two cycles
    always_ff @(posedge clk) begin
        ram_rd_data <= mem[ram_rd_addr];
        if (ld_en) mem[ld_a] <= ld_d;
        else if (ram_we) mem[ram_wr_addr] <= ram_wr_data;
    end

    always_ff @(posedge clk) if (ram_we) we_seen <= we_seen + 1;

    // {addr, rows, x, y, expected collision}
    localparam logic [27:0] VEC [7] = '{
        {12'h300, 4'd5,  6'd0,  5'd0,  1'b0},
        {12'h300, 4'd5,  6'd0,  5'd0,  1'b1},
        {12'h300, 4'd5,  6'd61, 5'd30, 1'b0},
        {12'h310, 4'd3,  6'd20, 5'd10, 1'b0},
        {12'h310, 4'd3,  6'd21, 5'd10, 1'b1},
        {12'hFFE, 4'd3,  6'd40, 5'd16, 1'b0},
        {12'h300, 4'd15, 6'd8,  5'd16, 1'b0}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic load(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        ld_en = 1'b1; ld_a = a; ld_d = d;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    // expected result from the requirement text (R3, R4, R5, R6)
    task automatic model(input logic [11:0] a, input int n, input int x,
                         input int y, output bit coll);
        coll = 1'b0;
        for (int k = 0; k < n; k++) begin
            logic [7:0]  s;
            logic [15:0] w;
            int rr, li, ri;
            s  = mem[12'(a + 12'(k))];
            w  = {s, 8'h00} >> (x % 8);
            rr = (y + k) % 32;
            li = rr * 8 + x / 8;
            ri = rr * 8 + ((x / 8 + 1) % 8);
            if ((ref_fb[li] & w[15:8]) != 0) coll = 1'b1;
            if ((ref_fb[ri] & w[7:0]) != 0)  coll = 1'b1;
            ref_fb[li] = ref_fb[li] ^ w[15:8];
            ref_fb[ri] = ref_fb[ri] ^ w[7:0];
        end
    endtask

    function automatic int fb_diff();
        int d = 0;
        for (int i = 0; i < 256; i++) if (mem[256 + i] !== ref_fb[i]) d++;
        return d;
    endfunction

    task automatic start(input logic [11:0] a, input logic [3:0] n,
                         input logic [5:0] x, input logic [4:0] y);
        @(negedge clk);
        draw = 1'b1; spr_addr = a; spr_rows = n; pos_x = x; pos_y = y;
        @(negedge clk);
        draw = 1'b0;
    endtask

    task automatic wait_idle(output int cyc);
        cyc = 0;
        while (busy && cyc < 1000) begin
            cyc++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int  cyc;
        bit  mcoll;
        int  we0;
        for (int i = 0; i < 256; i++) ref_fb[i] = 8'h00;
        // R1 reset values
        repeat (2) @(negedge clk);
        chk(!busy, "R1", "busy in reset", busy, 0);
        chk(!collision, "R1", "collision in reset", collision, 0);
        chk(!ram_we, "R1", "we in reset", ram_we, 0);
        for (int i = 0; i < 256; i++) load(12'(256 + i), 8'h00);
        load(12'h300, 8'h3C); load(12'h301, 8'h42); load(12'h302, 8'h81);
        load(12'h303, 8'hFF); load(12'h304, 8'h18);
        for (int i = 5; i < 16; i++) load(12'(12'h300 + i), 8'(i * 37 + 11));
        load(12'h310, 8'hFF); load(12'h311, 8'h81); load(12'h312, 8'hFF);
        load(12'hFFE, 8'h99); load(12'hFFF, 8'h66); load(12'h000, 8'h55);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !collision && !ram_we, "R1", "state after reset",
            {busy, collision, ram_we}, 0);

        // vector table: R2 busy length, R3/R4/R5/R9 framebuffer, R6 collision
        foreach (VEC[v]) begin
            logic [11:0] a;
            logic [3:0]  n;
            logic [5:0]  x;
            logic [4:0]  y;
            logic        ec;
            {a, n, x, y, ec} = VEC[v];
            model(a, int'(n), int'(x), int'(y), mcoll);
            start(a, n, x, y);
            wait_idle(cyc);
            chk(cyc == 5 * int'(n) + 1, "R2", "busy cycles", cyc, 5 * int'(n) + 1);
            chk(collision == ec && mcoll == ec, "R6", "collision", collision, ec);
            chk(fb_diff() == 0, "R5", "framebuffer bytes differing", fb_diff(), 0);
        end

        // R7: request while busy is ignored
        model(12'h310, 3, 0, 20, mcoll);
        start(12'h310, 4'd3, 6'd0, 5'd20);
        repeat (4) @(negedge clk);
        draw = 1'b1; spr_addr = 12'h300; spr_rows = 4'd2; pos_x = 6'd50; pos_y = 5'd5;
        @(negedge clk);
        draw = 1'b0;
        wait_idle(cyc);
        chk(cyc == 16 - 5, "R7", "remaining busy cycles", cyc, 11);
        chk(fb_diff() == 0, "R7", "framebuffer after ignored request", fb_diff(), 0);
        chk(collision == mcoll, "R7", "collision", collision, mcoll);

        // R6 hold: same one-row sprite twice gives collision, which persists
        model(12'h310, 1, 56, 26, mcoll);
        start(12'h310, 4'd1, 6'd56, 5'd26);
        wait_idle(cyc);
        model(12'h310, 1, 56, 26, mcoll);
        start(12'h310, 4'd1, 6'd56, 5'd26);
        wait_idle(cyc);
        repeat (10) @(negedge clk);
        chk(collision == 1'b1 && mcoll, "R6", "collision held", collision, 1);
        chk(fb_diff() == 0, "R4", "wrapped row restored", fb_diff(), 0);

        // R8: zero rows
        we0 = we_seen;
        start(12'h300, 4'd0, 6'd3, 5'd3);
        chk(!busy, "R8", "busy after empty request", busy, 0);
        chk(!collision, "R8", "collision cleared", collision, 0);
        repeat (10) @(negedge clk);
        chk(we_seen == we0, "R8", "writes issued", we_seen - we0, 0);
        chk(fb_diff() == 0, "R8", "framebuffer unchanged", fb_diff(), 0);

        // R1: reset in the middle of a draw
        start(12'h310, 4'd3, 6'd20, 5'd10);
        repeat (6) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(!busy && !collision && !ram_we, "R1", "state after mid-draw reset",
            {busy, collision, ram_we}, 0);
        rst = 1'b0;
        @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule